// File: doc/BRIEF.md
# Receive Link Qualifier and Fault Monitor

This block serves one receive channel. Each bit-clock cycle it takes one recovered serial bit and decides whether the clock-recovery loop should follow the incoming data or fall back to the local reference clock. Two serial inputs are available, and a select line picks the one that feeds the run-length checker.

The qualification uses three inputs: an amplitude-valid flag, a frequency-in-range flag, and an internal check that the line shows at least one transition in every 60 bits. A detector-enable control can reduce the qualification to the range flag alone. A recover-enable control, when low, forces the loop onto the reference clock. The block also drives an active-low link-fault output, which is the OR of six fault conditions. Both outputs come from registers.

Top module: `rx_link_qualifier`

## Requirements
- R1: When `in_sel_i` is 1, the run-length checker takes `bit_pri_i`. When it is 0, the checker takes `bit_sec_i`. The unselected line has no effect on either output.
- R2: The density check fails once the last 60 received bits are all equal. A run of 59 equal bits does not fail it.
- R3: A failed density check clears at the first received bit that differs from the bit before it. The internal run count never exceeds 60.
- R4: With `det_en_i`=1 and `recover_en_i`=1, `lock_data_o` (1 = track data, 0 = track reference) is 1 only when `amp_ok_i`=1, `range_ok_i`=1 and the density check passes.
- R5: With `det_en_i`=0 and `recover_en_i`=1, `lock_data_o` equals `range_ok_i`. Amplitude and density have no effect on it.
- R6: With `recover_en_i`=0, `lock_data_o` is 0 and `link_fault_n_o` is 0 whatever the detector states are.
- R7: `link_fault_n_o` is 0 when any of these holds: `range_ok_i`=0, `amp_ok_i`=0, `chan_en_i`=0, `recover_en_i`=0, `refclk_ok_i`=0, or a failed density check while `det_en_i`=1. Otherwise it is 1. A clean link (`link_fault_n_o`=1) always has `lock_data_o`=1.
- R8: While the synchronous active-high `rst` is 1, the run count is cleared and both outputs are 0. The outputs first respond to inputs at the first clock edge after reset is released.
- R9: Both outputs update at the clock edge that samples a flag change. A received bit affects the outputs one edge later than a flag does, because it first passes through the run counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_pri_i | input | 1 | Recovered bit from the primary input |
| bit_sec_i | input | 1 | Recovered bit from the secondary input |
| in_sel_i | input | 1 | 1 selects primary, 0 selects secondary |
| det_en_i | input | 1 | Enables the amplitude and density qualification |
| recover_en_i | input | 1 | 0 forces the reference clock and signals a fault |
| amp_ok_i | input | 1 | Amplitude above threshold |
| range_ok_i | input | 1 | Data rate within expected range |
| refclk_ok_i | input | 1 | Reference clock present |
| chan_en_i | input | 1 | Receive channel enabled |
| lock_data_o | output | 1 | 1 = loop tracks data, 0 = tracks reference |
| link_fault_n_o | output | 1 | Link fault, active low |

## Verification
Some properties are checked by assertions on every cycle:
- the run-count bound;
- the clearing of a failed density check after a transition;
- the override by recover-enable;
- range-only locking when the detectors are disabled;
- the rule that a clean link is locked;
- the reset state.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the exact 59-versus-60 run boundary;
- the routing of each serial input by the select line;
- each of the six fault causes taken alone;
- the one-edge extra delay of bit-driven changes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned RUN_LIMIT_DEF = 60;

  typedef enum logic {
    SRC_REFCLK = 1'b0,
    SRC_DATA   = 1'b1
  } lock_src_e;

  // Lock source decision for one channel
  function automatic lock_src_e pick_source(
    input logic recover_en,
    input logic det_en,
    input logic amp_ok,
    input logic range_ok,
    input logic dens_fail
  );
    logic qualified;
    if (det_en) qualified = amp_ok & range_ok & ~dens_fail;
    else        qualified = range_ok;
    return (recover_en & qualified) ? SRC_DATA : SRC_REFCLK;
  endfunction

  // True when any of the six fault causes is present
  function automatic logic fault_present(
    input logic recover_en,
    input logic det_en,
    input logic amp_ok,
    input logic range_ok,
    input logic refclk_ok,
    input logic chan_en,
    input logic dens_fail
  );
    return ~range_ok | ~amp_ok | (det_en & dens_fail) |
           ~chan_en | ~recover_en | ~refclk_ok;
  endfunction

endpackage

// File: rtl/rxq_input_mux.sv
module rxq_input_mux (
  input  logic bit_pri_i,
  input  logic bit_sec_i,
  input  logic in_sel_i,
  output logic bit_o
);
  always_comb begin
    if (in_sel_i) bit_o = bit_pri_i;
    else          bit_o = bit_sec_i;
  end
endmodule

// File: rtl/rxq_run_counter.sv
module rxq_run_counter #(
  parameter int unsigned RUN_LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  output logic dens_fail_o,
  output logic edge_seen_o
);
  localparam int unsigned CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(RUN_LIMIT);

  logic          prev_q;
  logic [CW-1:0] run_q;

  function automatic logic [CW-1:0] next_run(input logic [CW-1:0] cur,
                                             input logic toggled);
    if (toggled)             return CW'(1);
    else if (cur == LIMIT_V) return cur;
    else                     return cur + CW'(1);
  endfunction

  assign edge_seen_o = (bit_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= bit_i;
      run_q  <= next_run(run_q, edge_seen_o);
    end
  end

  assign dens_fail_o = (run_q == LIMIT_V);

  // R3: run count stays within the limit
  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    run_q <= LIMIT_V);

  // R3: a transition clears a density failure at the next edge
  assert_fail_clears_R3: assert property (@(posedge clk) disable iff (rst)
    edge_seen_o |=> !dens_fail_o);

  // R2: an established failure persists while the line stays flat
  assert_fail_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (dens_fail_o && !edge_seen_o) |=> dens_fail_o);
endmodule

// File: rtl/rxq_decision.sv
module rxq_decision
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic det_en_i,
  input  logic recover_en_i,
  input  logic amp_ok_i,
  input  logic range_ok_i,
  input  logic refclk_ok_i,
  input  logic chan_en_i,
  input  logic dens_fail_i,
  output logic lock_data_o,
  output logic link_fault_n_o
);
  lock_src_e src_d, src_q;
  logic      fault_d, fault_n_q;

  always_comb begin
    src_d   = pick_source(recover_en_i, det_en_i, amp_ok_i, range_ok_i, dens_fail_i);
    fault_d = fault_present(recover_en_i, det_en_i, amp_ok_i, range_ok_i,
                            refclk_ok_i, chan_en_i, dens_fail_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_REFCLK;
      fault_n_q <= 1'b0;
    end else begin
      src_q     <= src_d;
      fault_n_q <= ~fault_d;
    end
  end

  assign lock_data_o    = (src_q == SRC_DATA);
  assign link_fault_n_o = fault_n_q;

  // R6: recover-enable low forces reference clock and a fault
  assert_local_forced_R6: assert property (@(posedge clk) disable iff (rst)
    !recover_en_i |=> (!lock_data_o && !link_fault_n_o));

  // R5: with detectors disabled only the range flag matters
  assert_range_only_R5: assert property (@(posedge clk) disable iff (rst)
    (!det_en_i && recover_en_i) |=> (lock_data_o == $past(range_ok_i)));

  // R7: a clean link is always locked to data
  assert_clean_locked_R7: assert property (@(posedge clk) disable iff (rst)
    link_fault_n_o |-> lock_data_o);

  // R8: reset puts both outputs in their safe state
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!lock_data_o && !link_fault_n_o));
endmodule

// File: rtl/rx_link_qualifier.sv
module rx_link_qualifier #(
  parameter int unsigned RUN_LIMIT = rxq_pkg::RUN_LIMIT_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_pri_i,
  input  logic bit_sec_i,
  input  logic in_sel_i,
  input  logic det_en_i,
  input  logic recover_en_i,
  input  logic amp_ok_i,
  input  logic range_ok_i,
  input  logic refclk_ok_i,
  input  logic chan_en_i,
  output logic lock_data_o,
  output logic link_fault_n_o
);
  logic sel_bit;
  logic dens_fail;
  logic edge_seen;

  rxq_input_mux u_mux (
    .bit_pri_i (bit_pri_i),
    .bit_sec_i (bit_sec_i),
    .in_sel_i  (in_sel_i),
    .bit_o     (sel_bit)
  );

  rxq_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk         (clk),
    .rst         (rst),
    .bit_i       (sel_bit),
    .dens_fail_o (dens_fail),
    .edge_seen_o (edge_seen)
  );

  rxq_decision u_dec (
    .clk            (clk),
    .rst            (rst),
    .det_en_i       (det_en_i),
    .recover_en_i   (recover_en_i),
    .amp_ok_i       (amp_ok_i),
    .range_ok_i     (range_ok_i),
    .refclk_ok_i    (refclk_ok_i),
    .chan_en_i      (chan_en_i),
    .dens_fail_i    (dens_fail),
    .lock_data_o    (lock_data_o),
    .link_fault_n_o (link_fault_n_o)
  );

  // R4: a locked output with detectors on implies no density failure one edge earlier
  assert_lock_needs_density_R4: assert property (@(posedge clk) disable iff (rst)
    (det_en_i && dens_fail && !edge_seen) |=> !lock_data_o);
endmodule

// File: tb/test_rx_link_qualifier.sv
module test_rx_link_qualifier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_pri = 1'b0, bit_sec = 1'b0, in_sel = 1'b1;
  logic det_en = 1'b1, recover_en = 1'b1, amp_ok = 1'b1, range_ok = 1'b1;
  logic refclk_ok = 1'b1, chan_en = 1'b1;
  logic lock_o, fault_n_o;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R8";
  bit pat_pri_toggle = 1'b1, pat_sec_toggle = 1'b1;

  bit exp_lock = 1'b0, exp_fault_n = 1'b0;
  bit hist[$];

  always #10 clk = ~clk;

  rx_link_qualifier i_rx_link_qualifier (
    .clk(clk), .rst(rst), .bit_pri_i(bit_pri), .bit_sec_i(bit_sec),
    .in_sel_i(in_sel), .det_en_i(det_en), .recover_en_i(recover_en),
    .amp_ok_i(amp_ok), .range_ok_i(range_ok), .refclk_ok_i(refclk_ok),
    .chan_en_i(chan_en), .lock_data_o(lock_o), .link_fault_n_o(fault_n_o)
  );

  // Reference model: keeps the last 60 selected bits
  function automatic bit flat_line();
    if (hist.size() < 60) return 1'b0;
    foreach (hist[i]) if (hist[i] != hist[0]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      exp_lock    = 1'b0;
      exp_fault_n = 1'b0;
    end else begin
      bit flat;
      bit sb;
      flat = flat_line();
      if (!recover_en)  exp_lock = 1'b0;
      else if (det_en)  exp_lock = amp_ok && range_ok && !flat;
      else              exp_lock = range_ok;
      exp_fault_n = range_ok && amp_ok && chan_en && recover_en && refclk_ok
                    && !(det_en && flat);
      sb = in_sel ? bit_pri : bit_sec;
      hist.push_back(sb);
      if (hist.size() > 60) void'(hist.pop_front());
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    check(lock_o === exp_lock, phase, "lock_data_o", lock_o, exp_lock);
    check(fault_n_o === exp_fault_n, phase, "link_fault_n_o", fault_n_o, exp_fault_n);
    if (cycles > 20000) begin
      check(1'b0, "watchdog", "run time", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pat_pri_toggle) bit_pri = ~bit_pri;
      if (pat_sec_toggle) bit_sec = ~bit_sec;
    end
  endtask

  initial begin
    phase = "R8";
    step(3);
    check(lock_o === 1'b0 && fault_n_o === 1'b0, "R8", "reset outputs",
          {lock_o, fault_n_o}, 0);
    @(negedge clk); rst = 1'b0;
    step(1);
    check(lock_o === 1'b1 && fault_n_o === 1'b1, "R8", "first edge after release",
          {lock_o, fault_n_o}, 3);

    phase = "R4"; step(10);
    check(lock_o === 1'b1, "R4", "toggling line locks", lock_o, 1);

    // R2 boundary: 59 equal bits tolerated
    phase = "R2";
    pat_pri_toggle = 1'b0;
    @(negedge clk); bit_pri = ~bit_pri;
    step(58);
    @(negedge clk); bit_pri = ~bit_pri;
    step(2);
    check(lock_o === 1'b1, "R2", "59-bit run tolerated", lock_o, 1);
    // 60 equal bits fail
    step(59);
    step(2);
    check(lock_o === 1'b0 && fault_n_o === 1'b0, "R2", "60-bit run fails",
          {lock_o, fault_n_o}, 0);

    phase = "R3";
    @(negedge clk); bit_pri = ~bit_pri;
    step(2);
    check(lock_o === 1'b1, "R3", "transition clears failure", lock_o, 1);
    step(80);

    phase = "R5";
    det_en = 1'b0;
    step(3);
    check(lock_o === 1'b1 && fault_n_o === 1'b1, "R5", "flat line ignored",
          {lock_o, fault_n_o}, 3);
    amp_ok = 1'b0; step(3);
    check(lock_o === 1'b1 && fault_n_o === 1'b0, "R5", "amplitude ignored for lock",
          {lock_o, fault_n_o}, 2);
    amp_ok = 1'b1; range_ok = 1'b0; step(3);
    check(lock_o === 1'b0, "R5", "range decides", lock_o, 0);
    range_ok = 1'b1;
    pat_pri_toggle = 1'b1;
    det_en = 1'b1;
    step(5);

    phase = "R9";
    @(negedge clk); amp_ok = 1'b0;
    @(negedge clk);
    check(lock_o === 1'b0 && fault_n_o === 1'b0, "R9", "one-edge flag latency",
          {lock_o, fault_n_o}, 0);
    amp_ok = 1'b1; step(3);

    phase = "R7";
    @(negedge clk); chan_en = 1'b0;   step(2);
    check(fault_n_o === 1'b0 && lock_o === 1'b1, "R7", "channel disabled", fault_n_o, 0);
    chan_en = 1'b1; refclk_ok = 1'b0; step(2);
    check(fault_n_o === 1'b0, "R7", "reference absent", fault_n_o, 0);
    refclk_ok = 1'b1; range_ok = 1'b0; step(2);
    check(fault_n_o === 1'b0, "R7", "range fault", fault_n_o, 0);
    range_ok = 1'b1; step(3);
    check(fault_n_o === 1'b1, "R7", "all clear", fault_n_o, 1);

    phase = "R6";
    recover_en = 1'b0; step(3);
    check(lock_o === 1'b0 && fault_n_o === 1'b0, "R6", "local clock forced",
          {lock_o, fault_n_o}, 0);
    recover_en = 1'b1; step(3);

    phase = "R1";
    pat_pri_toggle = 1'b0; pat_sec_toggle = 1'b1;
    in_sel = 1'b0; step(80);
    check(lock_o === 1'b1, "R1", "secondary toggling selected", lock_o, 1);
    in_sel = 1'b1; step(65);
    check(lock_o === 1'b0, "R1", "flat primary selected", lock_o, 0);
    pat_pri_toggle = 1'b1; step(5);

    phase = "R8";
    @(negedge clk); rst = 1'b1; step(2);
    check(lock_o === 1'b0 && fault_n_o === 1'b0, "R8", "reset mid-run",
          {lock_o, fault_n_o}, 0);
    rst = 1'b0; step(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule